// File: doc/BRIEF.md
# Indexed Effective Address Unit

This unit resolves the indexed addressing form of an 8-bit processor with a 16-bit address space. A start pulse hands it an indexed postbyte together with the four pointer registers, the two accumulators and the program counter value that points just past the postbyte. The unit captures all of these. It then pulls any offset bytes from the instruction stream and, for indirect forms, reads a 16-bit pointer from memory. Finally it raises a one-cycle done pulse carrying the effective address, an illegal-form flag and any pointer writeback.

Memory reads go out on a request channel and come back on a response channel. A read request (`rd_req_valid`, `rd_req_addr`) stays asserted with a stable address until the cycle in which `rd_req_ready` is high. That cycle is the handshake, and the memory may hold off a request for any number of cycles. At most one read is outstanding. After the handshake the unit waits for exactly one `rd_rsp_valid` beat. The unit never stalls a response, so the response channel has no ready. Responses that arrive while no read is outstanding are ignored. `start` is honoured only when `busy` is low.

Top module: `idx_ea_unit`

## Requirements
- R1: Postbyte bits 6:5 pick the base pointer: 0 picks X, 1 picks Y, 2 picks U and 3 picks S. For every form with a writeback, `wb_sel` carries this index.
- R2: With postbyte bit 7 clear, the effective address is the base pointer plus the sign-extended 5-bit field in bits 4:0. There are no reads and no writeback.
- R3: With bit 7 set, low nibble 0 or 1 is a post-increment by 1 or 2. The address is the unchanged pointer, and the writeback value is the pointer plus 1 or 2.
- R4: Low nibble 2 or 3 is a pre-decrement by 1 or 2. The pointer minus 1 or 2 is both the address and the writeback value.
- R5: Low nibble 4 adds nothing to the pointer. Nibble 5 adds B sign-extended, nibble 6 adds A sign-extended, and nibble 0xB adds the 16-bit value formed with A as the high byte and B as the low byte.
- R6: Low nibble 8 reads one signed byte from the stream at the captured PC. Nibble 9 reads two bytes, from PC and PC+1, that form a big-endian 16-bit offset. The offset is added to the pointer.
- R7: Low nibble 0xC or 0xD fetches an 8-bit or 16-bit offset in the same way as R6. The offset is added to the captured PC plus the number of offset bytes fetched, instead of to the pointer.
- R8: With bits 7 and 4 set, the address computed as above is dereferenced. Two bytes are read at that address and the following one, high byte first, and become the effective address. Nibble 0xF with bit 4 set takes a 16-bit absolute address from the stream and dereferences it.
- R9: Nibbles 7, 0xA and 0xE are illegal. So are nibble 0 or 2 with bit 4 set, and nibble 0xF with bit 4 clear. An illegal form makes no reads and gives done with `illegal`=1, `wb_en`=0 and `ea`=0.
- R10: A read request keeps `rd_req_valid` high and `rd_req_addr` stable until it is accepted. All stream reads come before any pointer read.
- R11: After reset, `busy`, `done` and `rd_req_valid` are low. `done` is a single-cycle pulse. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving `postbyte` (honoured when not busy) |
| postbyte | input | 8 | Indexed-mode postbyte |
| reg_x | input | 16 | Pointer X |
| reg_y | input | 16 | Pointer Y |
| reg_u | input | 16 | Pointer U |
| reg_s | input | 16 | Pointer S |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc_next | input | 16 | Address of the byte after the postbyte |
| busy | output | 1 | A request is in progress |
| rd_req_valid | output | 1 | Byte read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | 16 | Byte read address |
| rd_rsp_valid | input | 1 | Read data beat |
| rd_rsp_data | input | 8 | Read data |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address (valid with done) |
| illegal | output | 1 | Postbyte form undefined (valid with done) |
| wb_en | output | 1 | Pointer writeback requested (valid with done) |
| wb_sel | output | 2 | Pointer index to write back, 0..3 for X, Y, U, S |
| wb_value | output | 16 | New pointer value |

## Verification
The bench builds the unit with its default widths: 16-bit addresses and 8-bit data. At these widths all 256 postbytes can be swept against three register sets. The first set has typical values, the second sits on the 0x0000/0xFFFF wrap with accumulators at the sign boundary, and the third has mixed signs. Every sign extension, carry-out and illegal combination is therefore reached. Memory data is a fixed arithmetic function of the address, and the ready line drops periodically. This makes request hold under back-pressure, read ordering and big-endian assembly observable.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    M_OFS5, M_INC1, M_INC2, M_DEC1, M_DEC2, M_ZERO, M_ACCB, M_ACCA,
    M_ACCD, M_OFS8, M_OFS16, M_PC8, M_PC16, M_EXT
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic       ind;
    logic       illegal;
    logic [1:0] nbytes;
    logic [1:0] ptr;
    logic [4:0] ofs5;
  } dec_t;

  typedef enum logic [2:0] {S_IDLE, S_OFS, S_CALC, S_IND, S_DONE} st_e;
endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
  import idx_ea_pkg::*;
(
  input  logic [7:0] pb,
  output dec_t       dec
);
  always_comb begin
    dec         = '0;
    dec.mode    = M_OFS5;
    dec.ptr     = pb[6:5];
    dec.ofs5    = pb[4:0];
    if (pb[7]) begin
      dec.ind = pb[4];
      unique case (pb[3:0])
        4'h0: begin dec.mode = M_INC1; dec.illegal = pb[4]; end
        4'h1: dec.mode = M_INC2;
        4'h2: begin dec.mode = M_DEC1; dec.illegal = pb[4]; end
        4'h3: dec.mode = M_DEC2;
        4'h4: dec.mode = M_ZERO;
        4'h5: dec.mode = M_ACCB;
        4'h6: dec.mode = M_ACCA;
        4'h8: begin dec.mode = M_OFS8;  dec.nbytes = 2'd1; end
        4'h9: begin dec.mode = M_OFS16; dec.nbytes = 2'd2; end
        4'hB: dec.mode = M_ACCD;
        4'hC: begin dec.mode = M_PC8;   dec.nbytes = 2'd1; end
        4'hD: begin dec.mode = M_PC16;  dec.nbytes = 2'd2; end
        4'hF: begin dec.mode = M_EXT;   dec.nbytes = 2'd2; dec.illegal = ~pb[4]; end
        default: dec.illegal = 1'b1;
      endcase
    end
  end

  // single-step auto-modify never survives as a legal indirect form (R9)
  always_comb begin
    if (!dec.illegal && dec.ind)
      p_no_ind_single_r9: assert (dec.mode != M_INC1 && dec.mode != M_DEC1);
  end
endmodule

// File: rtl/idx_ea_addgen.sv
module idx_ea_addgen
  import idx_ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  dec_t                  dec,
  input  logic [3:0][AW-1:0]    ptrs,
  input  logic [DW-1:0]         acc_a,
  input  logic [DW-1:0]         acc_b,
  input  logic [AW-1:0]         pc,
  input  logic [AW-1:0]         ofs_buf,
  output logic [AW-1:0]         ea_pre,
  output logic [AW-1:0]         wb_value,
  output logic                  wb_en
);
  localparam int EXT_W = AW - DW;

  logic [AW-1:0] base, ofs, sum, ptr;

  assign ptr = ptrs[dec.ptr];

  always_comb begin
    base = ptr;
    ofs  = '0;
    unique case (dec.mode)
      M_OFS5:  ofs = {{(AW-5){dec.ofs5[4]}}, dec.ofs5};
      M_DEC1:  ofs = '1;
      M_DEC2:  ofs = {{(AW-1){1'b1}}, 1'b0};
      M_ACCB:  ofs = {{EXT_W{acc_b[DW-1]}}, acc_b};
      M_ACCA:  ofs = {{EXT_W{acc_a[DW-1]}}, acc_a};
      M_ACCD:  ofs = {acc_a, acc_b};
      M_OFS8:  ofs = {{EXT_W{ofs_buf[DW-1]}}, ofs_buf[DW-1:0]};
      M_OFS16: ofs = ofs_buf;
      M_PC8: begin
        base = pc + AW'(dec.nbytes);
        ofs  = {{EXT_W{ofs_buf[DW-1]}}, ofs_buf[DW-1:0]};
      end
      M_PC16: begin
        base = pc + AW'(dec.nbytes);
        ofs  = ofs_buf;
      end
      M_EXT: begin
        base = '0;
        ofs  = ofs_buf;
      end
      default: ofs = '0;
    endcase
  end

  assign sum = base + ofs;

  always_comb begin
    wb_en    = 1'b0;
    wb_value = sum;
    ea_pre   = sum;
    unique case (dec.mode)
      M_INC1: begin wb_en = 1'b1; wb_value = ptr + AW'(1); ea_pre = ptr; end
      M_INC2: begin wb_en = 1'b1; wb_value = ptr + AW'(2); ea_pre = ptr; end
      M_DEC1, M_DEC2: wb_en = 1'b1;
      default: wb_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    postbyte,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_u,
  input  logic [AW-1:0] reg_s,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  input  logic [AW-1:0] pc_next,
  output logic          busy,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          illegal,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_value
);
  st_e                state;
  dec_t               dec_in, dec_r;
  logic [3:0][AW-1:0] ptr_r, ptr_in;
  logic [DW-1:0]      a_r, b_r, hi_r;
  logic [AW-1:0]      pc_r, ofs_buf, ea_r, wbv_r, ea_pre, wbv_c;
  logic               cnt, wait_r, ill_r, wbe_r, wbe_c;
  logic [1:0]         sel_r;
  logic               req_fire, rsp_take, last_ofs;

  idx_ea_decode u_dec (.pb(postbyte), .dec(dec_in));

  idx_ea_addgen #(.AW(AW), .DW(DW)) u_add (
    .dec(dec_r), .ptrs(ptr_r), .acc_a(a_r), .acc_b(b_r), .pc(pc_r),
    .ofs_buf(ofs_buf), .ea_pre(ea_pre), .wb_value(wbv_c), .wb_en(wbe_c)
  );

  for (genvar g = 0; g < 4; g++) begin : g_ptr
    assign ptr_in[g] = (g == 0) ? reg_x : (g == 1) ? reg_y : (g == 2) ? reg_u : reg_s;
  end

  assign rd_req_valid = (state == S_OFS || state == S_IND) && !wait_r;
  assign rd_req_addr  = ((state == S_OFS) ? pc_r : ea_r) + AW'(cnt);
  assign req_fire     = rd_req_valid && rd_req_ready;
  assign rsp_take     = rd_rsp_valid && wait_r;
  assign last_ofs     = (2'(cnt) == dec_r.nbytes - 2'd1);
  assign busy         = (state != S_IDLE);
  assign done         = (state == S_DONE);
  assign ea           = ea_r;
  assign illegal      = ill_r;
  assign wb_en        = wbe_r;
  assign wb_sel       = sel_r;
  assign wb_value     = wbv_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; dec_r <= '0; ptr_r <= '0; a_r <= '0; b_r <= '0;
      pc_r <= '0; ofs_buf <= '0; hi_r <= '0; ea_r <= '0; wbv_r <= '0;
      cnt <= 1'b0; wait_r <= 1'b0; ill_r <= 1'b0; wbe_r <= 1'b0; sel_r <= '0;
    end else begin
      if (req_fire) wait_r <= 1'b1;
      if (rsp_take) wait_r <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          dec_r <= dec_in; ptr_r <= ptr_in; a_r <= acc_a; b_r <= acc_b;
          pc_r <= pc_next; cnt <= 1'b0; wait_r <= 1'b0; ofs_buf <= '0;
          ill_r <= dec_in.illegal; wbe_r <= 1'b0; ea_r <= '0; wbv_r <= '0;
          sel_r <= dec_in.ptr;
          if (dec_in.illegal)          state <= S_DONE;
          else if (dec_in.nbytes != 0) state <= S_OFS;
          else                         state <= S_CALC;
        end
        S_OFS: if (rsp_take) begin
          ofs_buf <= {ofs_buf[DW-1:0], rd_rsp_data};
          if (last_ofs) begin cnt <= 1'b0; state <= S_CALC; end
          else cnt <= 1'b1;
        end
        S_CALC: begin
          ea_r  <= ea_pre;
          wbe_r <= wbe_c;
          wbv_r <= wbv_c;
          state <= dec_r.ind ? S_IND : S_DONE;
        end
        S_IND: if (rsp_take) begin
          if (cnt) begin ea_r <= {hi_r, rd_rsp_data}; cnt <= 1'b0; state <= S_DONE; end
          else begin hi_r <= rd_rsp_data; cnt <= 1'b1; end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !done);
  p_illegal_nowb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && illegal |-> !wb_en && ea == '0);
  p_predec_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !dec_r.ind && (dec_r.mode == M_DEC1 || dec_r.mode == M_DEC2) |-> wb_en && wb_value == ea);
  p_postinc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && dec_r.mode == M_INC1 && !dec_r.ind |-> wb_value == ea + AW'(1));
endmodule

// File: tb/idx_ea_unit_bench.sv
`timescale 1ns/1ps
module idx_ea_unit_bench;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0]  postbyte = '0, acc_a = '0, acc_b = '0, rd_rsp_data;
  logic [15:0] reg_x = '0, reg_y = '0, reg_u = '0, reg_s = '0, pc_next = '0;
  logic        busy, rd_req_valid, rd_req_ready, rd_rsp_valid, done, illegal, wb_en;
  logic [15:0] rd_req_addr, ea, wb_value;
  logic [1:0]  wb_sel;

  int n_cmp = 0, n_bad = 0, nfetch = 0, hs_err = 0;
  logic [15:0] flog [16];
  logic        pend = 1'b0;
  logic [15:0] paddr = '0;
  logic [1:0]  rdy_cnt = '0;
  logic        prev_stall = 1'b0;
  logic [15:0] prev_addr = '0;

  always #2.5 clk = ~clk;

  idx_ea_unit u_idx_ea_unit (.*);

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  assign rd_req_ready = (rdy_cnt != 2'd1);
  assign rd_rsp_valid = pend;
  assign rd_rsp_data  = memf(paddr);

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 2'd1;
    if (pend) pend <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      pend <= 1'b1; paddr <= rd_req_addr;
      flog[nfetch % 16] <= rd_req_addr; nfetch <= nfetch + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && prev_stall && !(rd_req_valid && rd_req_addr == prev_addr)) hs_err <= hs_err + 1;
    prev_stall <= rst_n && rd_req_valid && !rd_req_ready;
    prev_addr  <= rd_req_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sx8(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  function automatic string tag_of(input logic [7:0] pb, input bit ill);
    if (!pb[7]) return "R1 R2";
    if (ill) return "R9";
    if (pb[4]) return "R8";
    case (pb[3:0])
      4'h0, 4'h1: return "R1 R3";
      4'h2, 4'h3: return "R1 R4";
      4'h8, 4'h9: return "R1 R6";
      4'hC, 4'hD: return "R7";
      default:    return "R1 R5";
    endcase
  endfunction

  task automatic run_op(input logic [7:0] pb, input bit poke);
    logic [15:0] p, ad, e_ea, e_wbv, xa [4];
    logic [3:0]  nb;
    logic        ill, ind, e_wbe;
    int          n0, cyc, nx;
    string       t;
    p = (pb[6:5] == 0) ? reg_x : (pb[6:5] == 1) ? reg_y : (pb[6:5] == 2) ? reg_u : reg_s;
    ill = 1'b0; ind = 1'b0; nb = 0; e_wbe = 1'b0; e_wbv = 16'h0; ad = p;
    if (!pb[7]) ad = p + {{11{pb[4]}}, pb[4:0]};
    else begin
      ind = pb[4];
      case (pb[3:0])
        4'h0: begin ill = ind; e_wbe = 1; e_wbv = p + 16'd1; end
        4'h1: begin e_wbe = 1; e_wbv = p + 16'd2; end
        4'h2: begin ill = ind; ad = p - 16'd1; e_wbe = 1; e_wbv = ad; end
        4'h3: begin ad = p - 16'd2; e_wbe = 1; e_wbv = ad; end
        4'h4: ;
        4'h5: ad = p + sx8(acc_b);
        4'h6: ad = p + sx8(acc_a);
        4'h8: begin nb = 1; ad = p + sx8(memf(pc_next)); end
        4'h9: begin nb = 2; ad = p + {memf(pc_next), memf(pc_next + 16'd1)}; end
        4'hB: ad = p + {acc_a, acc_b};
        4'hC: begin nb = 1; ad = pc_next + 16'd1 + sx8(memf(pc_next)); end
        4'hD: begin nb = 2; ad = pc_next + 16'd2 + {memf(pc_next), memf(pc_next + 16'd1)}; end
        4'hF: begin ill = ~ind; nb = 2; ad = {memf(pc_next), memf(pc_next + 16'd1)}; end
        default: ill = 1;
      endcase
    end
    nx = 0;
    if (!ill) begin
      for (int k = 0; k < int'(nb); k++) begin xa[nx] = pc_next + 16'(k); nx++; end
      if (ind) begin xa[nx] = ad; xa[nx+1] = ad + 16'd1; nx += 2; end
    end
    e_ea = ill ? 16'h0 : (ind ? {memf(ad), memf(ad + 16'd1)} : ad);
    if (ill) e_wbe = 0;
    t = tag_of(pb, ill);

    @(negedge clk);
    n0 = nfetch; postbyte = pb; start = 1'b1;
    @(negedge clk);
    start = 1'b0; postbyte = ~pb;
    if (poke) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    if (!done) begin n_cmp++; n_bad++; $display("FAIL R11 op %h no done", pb); return; end
    chk({t, " illegal"}, 32'(illegal), 32'(ill));
    chk({t, " ea"}, 32'(ea), 32'(e_ea));
    chk({t, " wb_en"}, 32'(wb_en), 32'(e_wbe));
    if (e_wbe) begin
      chk({t, " wb_value"}, 32'(wb_value), 32'(e_wbv));
      chk("R1 wb_sel", 32'(wb_sel), 32'(pb[6:5]));
    end
    chk("R10 fetch count", 32'(nfetch - n0), 32'(nx));
    for (int k = 0; k < nx; k++) chk("R6 R8 R10 fetch addr", 32'(flog[(n0 + k) % 16]), 32'(xa[k]));
    @(negedge clk);
    chk("R11 done pulse", 32'(done), 32'h0);
  endtask

  task automatic load_set(input int s);
    case (s)
      0: begin reg_x = 16'hF802; reg_y = 16'h8000; reg_u = 16'h2000; reg_s = 16'hF830;
               acc_a = 8'h55; acc_b = 8'hF0; pc_next = 16'hF812; end
      1: begin reg_x = 16'h0000; reg_y = 16'hFFFF; reg_u = 16'h7FFF; reg_s = 16'h0001;
               acc_a = 8'h80; acc_b = 8'h7F; pc_next = 16'hFFFE; end
      default: begin reg_x = 16'h1234; reg_y = 16'hABCD; reg_u = 16'h0FF0; reg_s = 16'h8001;
               acc_a = 8'hFF; acc_b = 8'h01; pc_next = 16'h0100; end
    endcase
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 reset busy", 32'(busy), 32'h0);
    chk("R11 reset done", 32'(done), 32'h0);
    chk("R11 reset req", 32'(rd_req_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    load_set(0);
    run_op(8'h09, 1'b0);
    run_op(8'h85, 1'b0);
    chk("R5 B sign-extended", 32'(ea), 32'h0000F7F2);
    for (int s = 0; s < 3; s++) begin
      load_set(s);
      for (int b = 0; b < 256; b++) run_op(8'(b), 1'b0);
    end
    load_set(2);
    run_op(8'h99, 1'b1);
    run_op(8'hAD, 1'b1);
    chk("R10 request held under back-pressure", 32'(hs_err), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule